// File: doc/BRIEF.md
# Serial Channel Clock Routing Unit

This block sits beside one serial channel and decides which clock each direction of the channel runs on. An 8-bit select register, loaded through a simple write port, chooses the receiver clock from four candidates and the transmitter clock from two. The candidates are:

- the internal baud generator tick;
- a dedicated receive clock pin;
- a modem-status pin repurposed as a clock input (DSR# for the receiver, RI# for the transmitter);
- for the receiver only, whatever clock the transmitter is using.

External pins are sampled asynchronously. Each one is synchronized and turned into a single-cycle enable in the system clock domain.

Each direction runs in one of two modes. In oversampled mode a divide-by-16 counter turns the selected clock into bit-period ticks, and on the receive side also into a mid-bit sample strobe. In isochronous 1x mode every selected clock edge is one bit period.

The same register controls two pins:

- The baud output pin either carries the baud generator tick or is held low.
- The shared modem-control output either carries its normal level, the transmit bit clock, or the baud generator clock.

A hardware reset clears the register. A channel software reset only restarts the divide counters, so software can pick a clock source first and then reset the channel cleanly.

Top module: `uart_clk_route`

## Requirements
- R1: Hardware reset (rst_n low) clears the select register to 0x00: receiver clocked from the receive clock pin, transmitter from the baud tick, both oversampled, baud output enabled, and dtrPin following dtrDefault. Pulsing softReset leaves the register value unchanged.
- R2: Bits [1:0] pick the receiver clock. 00 is rxClkPin rising edges, 01 is dsrPin rising edges, 10 is baudTick, and 11 is the clock currently selected for the transmitter. Sources that are not selected have no effect on rxBitTick or rxSample.
- R3: With bit 2 at 0, baudOutPin is high for one cycle per baudTick pulse. With bit 2 at 1, baudOutPin stays low.
- R4: With bit 3 at 0, the receiver counts selected clock edges modulo 16. rxSample pulses on the 8th edge of each group of 16 and rxBitTick on the 16th. With bit 3 at 1, both strobes pulse once for every selected edge.
- R5: Bits [5:4] set dtrPin. 00 and the reserved value 11 drive dtrDefault. 01 drives the transmit bit-period tick, identical to txBitTick. 10 drives the baudTick pulses. In modes 01 and 10, dtrDefault is ignored.
- R6: With bit 6 at 0, the transmitter is clocked by baudTick. With bit 6 at 1, it is clocked by riPin rising edges, and baudTick is ignored.
- R7: With bit 7 at 0, txBitTick pulses once per 16 selected transmit clock edges. With bit 7 at 1, it pulses once for every selected edge.
- R8: Each rising edge of rxClkPin, dsrPin or riPin passes through a two-flop synchronizer and yields exactly one single-cycle clock enable.
- R9: softReset clears both divide counters. A selected clock edge that arrives in the same cycle as softReset is discarded.
- R10: When cfgWrEn is high at a rising clock edge, cfgWrData is loaded into the select register, and the new routing applies from the next cycle. A write in the same cycle as softReset still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset, clears the select register |
| softReset | input | 1 | Channel software reset; restarts the divide counters only |
| cfgWrEn | input | 1 | Write strobe for the select register |
| cfgWrData | input | 8 | Value written to the select register |
| baudTick | input | 1 | Single-cycle tick from the internal baud generator (Nx clock) |
| rxClkPin | input | 1 | Asynchronous dedicated receive clock pin level |
| dsrPin | input | 1 | Asynchronous modem-status pin level usable as receive clock |
| riPin | input | 1 | Asynchronous modem-status pin level usable as transmit clock |
| dtrDefault | input | 1 | Normal modem-control level for the shared output pin |
| rxSample | output | 1 | Receiver bit-sample strobe |
| rxBitTick | output | 1 | Receiver bit-period tick |
| txBitTick | output | 1 | Transmitter bit-period tick |
| baudOutPin | output | 1 | Baud clock output pin level |
| dtrPin | output | 1 | Shared modem-control / clock output pin level |

## Verification
A software reset can land in the same cycle as a counted clock edge on the oversampled receive path. In that case the reset must win and the edge must be dropped. The bench provokes this by sending seven baud ticks and then raising softReset together with an eighth. It then counts rxSample pulses over the following ticks: none may appear after seven more ticks, and one must appear on the eighth. It also checks that the register kept the baud output disabled through that reset.

// File: rtl/uart_clk_route_pkg.sv
package uart_clk_route_pkg;

  // Select register layout, bit 7 down to bit 0
  typedef struct packed {
    logic       txIso;    // 7: transmitter 1x mode
    logic       txExt;    // 6: transmitter clocked from ring pin
    logic [1:0] dtrMode;  // 5:4: shared pin function
    logic       rxIso;    // 3: receiver 1x mode
    logic       baudOff;  // 2: baud output held low
    logic [1:0] rxSrc;    // 1:0: receiver clock source
  } clkSel_t;

  localparam logic [1:0] RX_SRC_PIN  = 2'b00;
  localparam logic [1:0] RX_SRC_DSR  = 2'b01;
  localparam logic [1:0] RX_SRC_BAUD = 2'b10;
  localparam logic [1:0] RX_SRC_TX   = 2'b11;

  localparam logic [1:0] DTR_NORMAL  = 2'b00;
  localparam logic [1:0] DTR_TXBIT   = 2'b01;
  localparam logic [1:0] DTR_BAUD    = 2'b10;

  // Strobes and modes from control to datapath
  typedef struct packed {
    logic       rxEdge;
    logic       txEdge;
    logic       baudEdge;
    logic       clear;
    logic       rxIso;
    logic       txIso;
    logic       baudOff;
    logic [1:0] dtrMode;
  } routeCtl_t;

endpackage

// File: rtl/uart_clk_route_sync.sv
module uart_clk_route_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pinIn,
  output logic risePulse
);

  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], pinIn};
  end

  // chain[STAGES-1] is the synchronized level, chain[STAGES] its delayed copy
  assign risePulse = chain[STAGES-1] & ~chain[STAGES];

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    risePulse |=> !risePulse);

endmodule

// File: rtl/uart_clk_route_ctrl.sv
module uart_clk_route_ctrl
  import uart_clk_route_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      softReset,
  input  logic      cfgWrEn,
  input  logic [7:0] cfgWrData,
  input  logic      baudTick,
  input  logic      rxClkPin,
  input  logic      dsrPin,
  input  logic      riPin,
  output routeCtl_t ctl
);

  localparam int N_PINS = 3;

  clkSel_t           sel;
  logic [N_PINS-1:0] pinVec;
  logic [N_PINS-1:0] pinEdge;
  logic              txEdge;
  logic              rxEdge;

  // Register: cleared only by hardware reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sel <= '0;
    else if (cfgWrEn) sel <= clkSel_t'(cfgWrData);
  end

  assign pinVec = {riPin, dsrPin, rxClkPin};

  for (genvar i = 0; i < N_PINS; i++) begin : g_pinSync
    uart_clk_route_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pinIn    (pinVec[i]),
      .risePulse(pinEdge[i])
    );
  end

  always_comb begin
    txEdge = sel.txExt ? pinEdge[2] : baudTick;
    unique case (sel.rxSrc)
      RX_SRC_PIN:  rxEdge = pinEdge[0];
      RX_SRC_DSR:  rxEdge = pinEdge[1];
      RX_SRC_BAUD: rxEdge = baudTick;
      default:     rxEdge = txEdge;
    endcase
  end

  always_comb begin
    ctl.rxEdge   = rxEdge;
    ctl.txEdge   = txEdge;
    ctl.baudEdge = baudTick;
    ctl.clear    = softReset;
    ctl.rxIso    = sel.rxIso;
    ctl.txIso    = sel.txIso;
    ctl.baudOff  = sel.baudOff;
    ctl.dtrMode  = sel.dtrMode;
  end

  assert_keep_on_soft_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (softReset && !cfgWrEn) |=> $stable(sel));

  assert_write_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfgWrEn |=> (sel == clkSel_t'($past(cfgWrData))));

endmodule

// File: rtl/uart_clk_route_dp.sv
module uart_clk_route_dp
  import uart_clk_route_pkg::*;
#(
  parameter int DIV_RATIO = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  routeCtl_t ctl,
  input  logic      dtrDefault,
  output logic      rxSample,
  output logic      rxBitTick,
  output logic      txBitTick,
  output logic      baudOutPin,
  output logic      dtrPin
);

  localparam int              CNT_W = $clog2(DIV_RATIO);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(DIV_RATIO / 2 - 1);

  logic [CNT_W-1:0] rxCnt, txCnt;
  logic rxTickNext, rxSmpNext, txTickNext;

  always_comb begin
    rxTickNext = ctl.rxEdge & (ctl.rxIso | (rxCnt == LAST));
    rxSmpNext  = ctl.rxEdge & (ctl.rxIso | (rxCnt == MID));
    txTickNext = ctl.txEdge & (ctl.txIso | (txCnt == LAST));
  end

  // Divide counters and bit strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxCnt     <= '0;
      txCnt     <= '0;
      rxBitTick <= 1'b0;
      rxSample  <= 1'b0;
      txBitTick <= 1'b0;
    end else if (ctl.clear) begin
      rxCnt     <= '0;
      txCnt     <= '0;
      rxBitTick <= 1'b0;
      rxSample  <= 1'b0;
      txBitTick <= 1'b0;
    end else begin
      if (ctl.rxEdge && !ctl.rxIso) rxCnt <= (rxCnt == LAST) ? '0 : rxCnt + 1'b1;
      if (ctl.txEdge && !ctl.txIso) txCnt <= (txCnt == LAST) ? '0 : txCnt + 1'b1;
      rxBitTick <= rxTickNext;
      rxSample  <= rxSmpNext;
      txBitTick <= txTickNext;
    end
  end

  // Pin drivers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baudOutPin <= 1'b0;
      dtrPin     <= 1'b0;
    end else begin
      baudOutPin <= ~ctl.baudOff & ctl.baudEdge;
      unique case (ctl.dtrMode)
        DTR_TXBIT: dtrPin <= txTickNext & ~ctl.clear;
        DTR_BAUD:  dtrPin <= ctl.baudEdge;
        default:   dtrPin <= dtrDefault;
      endcase
    end
  end

  assert_mid_before_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.rxIso && !$past(ctl.rxIso) && rxSample) |-> !rxBitTick);

  assert_tx_tick_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (txBitTick && !ctl.txIso) |=> (!txBitTick || ctl.txIso));

  assert_dtr_bitclock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl.dtrMode) == DTR_TXBIT && ctl.dtrMode == DTR_TXBIT) |-> (dtrPin == txBitTick));

  assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clear |=> (!rxBitTick && !rxSample && !txBitTick));

endmodule

// File: rtl/uart_clk_route.sv
module uart_clk_route
  import uart_clk_route_pkg::*;
#(
  parameter int DIV_RATIO   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       softReset,
  input  logic       cfgWrEn,
  input  logic [7:0] cfgWrData,
  input  logic       baudTick,
  input  logic       rxClkPin,
  input  logic       dsrPin,
  input  logic       riPin,
  input  logic       dtrDefault,
  output logic       rxSample,
  output logic       rxBitTick,
  output logic       txBitTick,
  output logic       baudOutPin,
  output logic       dtrPin
);

  routeCtl_t ctl;

  uart_clk_route_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .softReset(softReset),
    .cfgWrEn  (cfgWrEn),
    .cfgWrData(cfgWrData),
    .baudTick (baudTick),
    .rxClkPin (rxClkPin),
    .dsrPin   (dsrPin),
    .riPin    (riPin),
    .ctl      (ctl)
  );

  uart_clk_route_dp #(.DIV_RATIO(DIV_RATIO)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .dtrDefault(dtrDefault),
    .rxSample  (rxSample),
    .rxBitTick (rxBitTick),
    .txBitTick (txBitTick),
    .baudOutPin(baudOutPin),
    .dtrPin    (dtrPin)
  );

endmodule

// File: tb/uart_clk_route_tb.sv
`timescale 1ns/1ps
module uart_clk_route_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic softReset = 1'b0, cfgWrEn = 1'b0, baudTick = 1'b0;
  logic [7:0] cfgWrData = 8'h00;
  logic rxClkPin = 1'b0, dsrPin = 1'b0, riPin = 1'b0, dtrDefault = 1'b1;
  logic rxSample, rxBitTick, txBitTick, baudOutPin, dtrPin;

  int checks = 0, errors = 0;
  int nRxTick = 0, nRxSmp = 0, nTxTick = 0, nBaud = 0, nDtr = 0, nDouble = 0;
  logic prevRxTick = 1'b0;

  always #10 clk = ~clk;

  uart_clk_route u_dut (
    .clk(clk), .rst_n(rst_n), .softReset(softReset), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .baudTick(baudTick), .rxClkPin(rxClkPin),
    .dsrPin(dsrPin), .riPin(riPin), .dtrDefault(dtrDefault),
    .rxSample(rxSample), .rxBitTick(rxBitTick), .txBitTick(txBitTick),
    .baudOutPin(baudOutPin), .dtrPin(dtrPin)
  );

  always @(negedge clk) begin
    nRxTick  <= nRxTick + int'(rxBitTick);
    nRxSmp   <= nRxSmp + int'(rxSample);
    nTxTick  <= nTxTick + int'(txBitTick);
    nBaud    <= nBaud + int'(baudOutPin);
    nDtr     <= nDtr + int'(dtrPin);
    nDouble  <= nDouble + int'(rxBitTick && prevRxTick);
    prevRxTick <= rxBitTick;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic zeroCounts();
    @(negedge clk);
    nRxTick = 0; nRxSmp = 0; nTxTick = 0; nBaud = 0; nDtr = 0; nDouble = 0;
  endtask

  task automatic writeCfg(input logic [7:0] v);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk); cfgWrEn = 1'b0;
    settle();
    zeroCounts();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); baudTick = 1'b1;
      @(negedge clk); baudTick = 1'b0;
    end
    settle();
  endtask

  task automatic pulsePin(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      repeat (3) @(negedge clk);
      case (which) 0: rxClkPin = 1'b1; 1: dsrPin = 1'b1; default: riPin = 1'b1; endcase
      repeat (3) @(negedge clk);
      case (which) 0: rxClkPin = 1'b0; 1: dsrPin = 1'b0; default: riPin = 1'b0; endcase
    end
    settle();
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R1 reset rxBitTick", int'(rxBitTick), 0);
    chk("R1 reset txBitTick", int'(txBitTick), 0);
    chk("R1 reset baudOutPin", int'(baudOutPin), 0);
    rst_n = 1'b1;
    settle();
    chk("R1 dtr follows default after reset", int'(dtrPin), 1);
    zeroCounts();
    ticks(4);
    chk("R1 R3 baud output enabled after reset", nBaud, 4);
  endtask

  task automatic testNxBaud();
    writeCfg(8'h02);
    ticks(8);
    chk("R4 sample on 8th edge", nRxSmp, 1);
    chk("R4 no bit tick before 16th edge", nRxTick, 0);
    ticks(8);
    chk("R4 bit tick on 16th edge", nRxTick, 1);
    chk("R4 second sample after 16 edges", nRxSmp, 1);
    chk("R7 R6 tx Nx tick after 16 baud ticks", nTxTick, 1);
    chk("R3 baud pin pulses", nBaud, 16);
    ticks(32);
    chk("R4 three ticks after 48 edges", nRxTick, 3);
  endtask

  task automatic testBaudOff();
    writeCfg(8'h06);
    ticks(5);
    chk("R3 baud pin held low when disabled", nBaud, 0);
  endtask

  task automatic testRxPins();
    writeCfg(8'h08);
    pulsePin(0, 5);
    pulsePin(1, 3);
    chk("R2 R8 rx 1x from rx clock pin", nRxTick, 5);
    chk("R4 rx 1x sample per edge", nRxSmp, 5);
    chk("R8 single-cycle pin strobes", nDouble, 0);
    writeCfg(8'h09);
    pulsePin(1, 3);
    pulsePin(0, 4);
    ticks(4);
    chk("R2 rx 1x from dsr pin only", nRxTick, 3);
  endtask

  task automatic testTxRi();
    writeCfg(8'hCB);
    pulsePin(2, 4);
    ticks(10);
    chk("R6 R7 tx 1x from ring pin, baud ignored", nTxTick, 4);
    chk("R2 rx follows transmitter clock", nRxTick, 4);
    writeCfg(8'h40);
    pulsePin(2, 16);
    chk("R7 tx Nx from ring pin", nTxTick, 1);
  endtask

  task automatic testDtr();
    writeCfg(8'h90);
    dtrDefault = 1'b0;
    ticks(5);
    chk("R5 dtr carries tx bit clock", nDtr, 5);
    chk("R5 dtr pulses equal tx ticks", nTxTick, 5);
    writeCfg(8'h20);
    dtrDefault = 1'b1;
    ticks(7);
    chk("R5 dtr carries baud clock, default ignored", nDtr, 7);
    writeCfg(8'h30);
    dtrDefault = 1'b0; settle();
    chk("R5 reserved mode follows default low", int'(dtrPin), 0);
    dtrDefault = 1'b1; settle();
    chk("R5 reserved mode follows default high", int'(dtrPin), 1);
    writeCfg(8'h00);
    dtrDefault = 1'b0; settle();
    chk("R5 normal mode follows default", int'(dtrPin), 0);
  endtask

  task automatic testSoftReset();
    writeCfg(8'h06);
    ticks(7);
    @(negedge clk); baudTick = 1'b1; softReset = 1'b1;
    @(negedge clk); baudTick = 1'b0; softReset = 1'b0;
    settle();
    zeroCounts();
    ticks(7);
    chk("R9 edge with soft reset dropped", nRxSmp, 0);
    ticks(1);
    chk("R9 counter restarted by soft reset", nRxSmp, 1);
    chk("R1 register kept over soft reset", nBaud, 0);
    @(negedge clk); softReset = 1'b1; cfgWrEn = 1'b1; cfgWrData = 8'h02;
    @(negedge clk); softReset = 1'b0; cfgWrEn = 1'b0;
    settle(); zeroCounts();
    ticks(3);
    chk("R10 write wins over soft reset", nBaud, 3);
  endtask

  task automatic testHwReset();
    writeCfg(8'h06);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    settle(); zeroCounts();
    ticks(3);
    chk("R1 hardware reset clears register", nBaud, 3);
  endtask

  initial begin
    testReset();
    testNxBaud();
    testBaudOff();
    testRxPins();
    testTxRi();
    testDtr();
    testSoftReset();
    testHwReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule